// File: doc/BRIEF.md
# Read-Clock FIFO with Occupancy Counter and Half-Full Flag

This block is a sixteen-entry first-in first-out buffer that lives entirely in the reader's clock domain. The writer is a slow source whose request line has no fixed relation to that clock. Each rising edge of the request is brought through a two-stage synchronizer and turned into one single-cycle write strobe. At that strobe the value on the write data bus is stored. The writer must hold the data steady from the rising edge of its request until the write has been taken. Requests are expected at most once every several clock periods.

The read side runs at full speed. The oldest entry is always presented on the read data output while the buffer is not empty, and a read enable pops it on the next clock edge. Two four-bit pointers wrap naturally through the storage. A separate five-bit up/down occupancy counter tracks the fill level from 0 to 16. The counter drives the empty, full and half-full flags, so none of the flags depend on comparing the two pointers.

Top module: `rclk_fifo`

## Requirements
- R1: While reset is high, and on the first clock edge after it, empty is 1 and full and half_full are 0. Reset clears both pointers and the occupancy count.
- R2: Each rising edge of wr_req_async causes exactly one write, however long the request stays high. The write takes effect on the third rising clock edge after the request rises.
- R3: Entries leave in the order they were written.
- R4: empty is 1 exactly when the occupancy is 0, and full is 1 exactly when the occupancy is 16. Both are never 1 together.
- R5: half_full is 1 exactly when the occupancy is 8 or more.
- R6: When an accepted write and an accepted read fall on the same clock edge, the occupancy count is unchanged. The flags stay the same, including at occupancy 8.
- R7: A write strobe while full is ignored. No entry is stored and the stored contents and their order are unchanged.
- R8: rd_en while empty is ignored. The read pointer does not move and empty stays 1.
- R9: While not empty, rd_data shows the oldest stored entry with no read latency. Holding rd_en high pops one entry per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read-side clock; the whole block runs on it |
| rst | input | 1 | Synchronous active-high reset |
| wr_req_async | input | 1 | Write request from the slow writer; asynchronous to clk |
| wr_data | input | DATA_W | Write data; must be held stable while the request is high |
| rd_en | input | 1 | Pop the oldest entry on the next clock edge |
| rd_data | output | DATA_W | Oldest stored entry |
| empty | output | 1 | Occupancy is 0 |
| full | output | 1 | Occupancy is 16 |
| half_full | output | 1 | Occupancy is 8 or more |

## Verification
The hardest case to reach from the ports is a synchronized write strobe that lands on the same edge as a read. The strobe appears two edges after the request, hidden inside the synchronizer. The stimulus raises the request on a falling edge and asserts rd_en exactly two falling edges later, so the pop and the internal strobe share the third rising edge. It does this at occupancy 5 and at the half-full boundary of 8. It then drains the buffer and counts the entries that come out, which shows that the count held rather than moving up or down.

// File: rtl/rfifo_pkg.sv
package rfifo_pkg;

    localparam int DEF_DATA_W = 8;
    localparam int DEF_ADDR_W = 4;

    // Per-cycle action on the occupancy counter
    typedef enum logic [1:0] {
        OCC_HOLD = 2'd0,
        OCC_INC  = 2'd1,
        OCC_DEC  = 2'd2
    } occ_op_t;

    typedef struct packed {
        logic empty;
        logic full;
        logic half;
    } fifo_flags_t;

    // Choose the counter action from the accepted write and read
    function automatic occ_op_t pick_op(input logic wr_ok, input logic rd_ok);
        occ_op_t op;
        if (wr_ok && !rd_ok)      op = OCC_INC;
        else if (rd_ok && !wr_ok) op = OCC_DEC;
        else                      op = OCC_HOLD;
        return op;
    endfunction

endpackage

// File: rtl/rfifo_req_sync.sv
module rfifo_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req_async,
    output logic strobe
);
    // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], req_async};
    end

    assign strobe = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/rfifo_occ.sv
module rfifo_occ
    import rfifo_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    localparam int OCC_W = ADDR_W + 1,
    localparam int DEPTH = 1 << ADDR_W,
    localparam int HALF  = DEPTH / 2
) (
    input  logic             clk,
    input  logic             rst,
    input  occ_op_t          op,
    output logic [OCC_W-1:0] occ,
    output fifo_flags_t      flags
);
    always_ff @(posedge clk) begin
        if (rst) begin
            occ <= '0;
        end else begin
            unique case (op)
                OCC_INC: occ <= occ + 1'b1;
                OCC_DEC: occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    always_comb begin
        flags.empty = (occ == '0);
        flags.full  = (occ == OCC_W'(DEPTH));
        flags.half  = (occ >= OCC_W'(HALF));
    end
endmodule

// File: rtl/rfifo_store.sv
module rfifo_store #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ok,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_ok,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] wptr;
    logic [ADDR_W-1:0] rptr;

    // Pointers wrap naturally at the storage depth
    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (wr_ok) wptr <= wptr + 1'b1;
            if (rd_ok) rptr <= rptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr] <= wr_data;
    end

    assign rd_data = mem[rptr];
endmodule

// File: rtl/rclk_fifo.sv
module rclk_fifo
    import rfifo_pkg::*;
#(
    parameter int DATA_W    = DEF_DATA_W,
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int SYNC_STG  = 2,
    localparam int OCC_W    = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req_async,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              full,
    output logic              half_full
);
    logic             wr_stb;
    logic             wr_ok;
    logic             rd_ok;
    occ_op_t          op;
    logic [OCC_W-1:0] occ;
    fifo_flags_t      flags;

    rfifo_req_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .req_async (wr_req_async),
        .strobe    (wr_stb)
    );

    // Blocked accesses are dropped here, before they reach pointers or counter
    assign wr_ok = wr_stb && !flags.full;
    assign rd_ok = rd_en  && !flags.empty;
    assign op    = pick_op(wr_ok, rd_ok);

    rfifo_occ #(.ADDR_W(ADDR_W)) u_occ (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .occ   (occ),
        .flags (flags)
    );

    rfifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_ok   (wr_ok),
        .wr_data (wr_data),
        .rd_ok   (rd_ok),
        .rd_data (rd_data)
    );

    assign empty     = flags.empty;
    assign full      = flags.full;
    assign half_full = flags.half;
endmodule

// File: rtl/rclk_fifo_chk.sv
module rclk_fifo_chk #(
    parameter int OCC_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_stb,
    input logic             rd_en,
    input logic             empty,
    input logic             full,
    input logic             half_full,
    input logic [OCC_W-1:0] occ
);
    p_reset_flags_r1: assert property (@(posedge clk)
        rst |=> (empty && !full && !half_full));

    p_single_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    p_flags_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
        !(empty && full));

    p_full_implies_half_r5: assert property (@(posedge clk) disable iff (rst)
        full |-> half_full);

    p_both_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && rd_en && !empty && !full) |=> $stable(occ));

    p_full_block_r7: assert property (@(posedge clk) disable iff (rst)
        (full && wr_stb && !rd_en) |=> (full && $stable(occ)));

    p_empty_block_r8: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_en && !wr_stb) |=> (empty && $stable(occ)));
endmodule

bind rclk_fifo rclk_fifo_chk #(.OCC_W(OCC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_stb    (wr_stb),
    .rd_en     (rd_en),
    .empty     (empty),
    .full      (full),
    .half_full (half_full),
    .occ       (occ)
);

// File: tb/rclk_fifo_bench.sv
`timescale 1ns/1ps
module rclk_fifo_bench;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_req = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       empty, full, half_full;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] q[$];

    always #2.5 clk = ~clk;

    rclk_fifo u_rclk_fifo (
        .clk          (clk),
        .rst          (rst),
        .wr_req_async (wr_req),
        .wr_data      (wr_data),
        .rd_en        (rd_en),
        .rd_data      (rd_data),
        .empty        (empty),
        .full         (full),
        .half_full    (half_full)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_flags();
        int n = q.size();
        chk(empty == (n == 0), "R4", "empty", int'(empty), int'(n == 0));
        chk(full == (n == DEPTH), "R4", "full", int'(full), int'(n == DEPTH));
        chk(half_full == (n >= 8), "R5", "half_full", int'(half_full), int'(n >= 8));
    endtask

    // One complete write handshake; model accepts only when room exists
    task automatic push(input logic [7:0] v);
        wr_data = v;
        wr_req  = 1'b1;
        repeat (3) @(negedge clk);
        if (q.size() < DEPTH) q.push_back(v);
        wr_req = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Back-to-back reads, one per clock, checking data each cycle
    task automatic drain(input string req);
        rd_en = 1'b1;
        while (q.size() > 0) begin
            chk(rd_data == q[0], req, "rd_data", int'(rd_data), int'(q[0]));
            void'(q.pop_front());
            @(negedge clk);
            if (q.size() > 0) chk_flags();
        end
        rd_en = 1'b0;
        chk_flags();
    endtask

    // Request write and time a read to share the same edge as the strobe
    task automatic both_same_edge(input logic [7:0] v);
        wr_data = v;
        wr_req  = 1'b1;
        repeat (2) @(negedge clk);
        chk(rd_data == q[0], "R9", "head before shared edge", int'(rd_data), int'(q[0]));
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        void'(q.pop_front());
        q.push_back(v);
        chk_flags();
        wr_req = 1'b0;
        repeat (3) @(negedge clk);
        chk_flags();
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(empty == 1'b1, "R1", "empty in reset", int'(empty), 1);
        chk(full == 1'b0 && half_full == 1'b0, "R1", "full/half in reset",
            int'({full, half_full}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(empty == 1'b1, "R1", "empty after reset", int'(empty), 1);

        // R2: latency of three edges and one write for a long request
        wr_data = 8'h3C;
        wr_req  = 1'b1;
        repeat (2) @(negedge clk);
        chk(empty == 1'b1, "R2", "empty after two edges", int'(empty), 1);
        @(negedge clk);
        chk(empty == 1'b0, "R2", "empty after third edge", int'(empty), 0);
        chk(rd_data == 8'h3C, "R9", "first word visible", int'(rd_data), 8'h3C);
        repeat (10) @(negedge clk);
        wr_req = 1'b0;
        repeat (3) @(negedge clk);
        q.push_back(8'h3C);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        void'(q.pop_front());
        chk(empty == 1'b1, "R2", "single entry for held request", int'(empty), 1);

        // R4 R5: fill sweep across every occupancy 1..16
        for (int i = 0; i < DEPTH; i++) begin
            push(8'(i * 17 + 3));
            chk_flags();
        end
        // R7: write while full is dropped
        push(8'hEE);
        chk(full == 1'b1, "R7", "full after blocked write", int'(full), 1);
        chk(rd_data == 8'h03, "R7", "head unchanged", int'(rd_data), 8'h03);
        // R3 R9: drain in order, one per clock
        drain("R3");

        // R8: read while empty is ignored
        rd_en = 1'b1;
        repeat (2) @(negedge clk);
        rd_en = 1'b0;
        chk(empty == 1'b1, "R8", "empty after blocked read", int'(empty), 1);
        push(8'h5A);
        chk(rd_data == 8'h5A, "R8", "read pointer did not move", int'(rd_data), 8'h5A);
        drain("R8");

        // R6: shared edge at occupancy 5
        for (int i = 0; i < 5; i++) push(8'(8'hA0 + i));
        both_same_edge(8'hB5);
        drain("R6");

        // R6: shared edge at the half-full boundary
        for (int i = 0; i < 8; i++) push(8'(8'hC0 ^ (i * 9)));
        chk(half_full == 1'b1, "R5", "half at eight", int'(half_full), 1);
        both_same_edge(8'h77);
        chk(half_full == 1'b1, "R6", "half held at eight", int'(half_full), 1);
        drain("R6");

        // R3: interleaved pushes and single pops
        for (int i = 0; i < 6; i++) begin
            push(8'(8'h11 * i + 1));
            push(8'(8'h11 * i + 2));
            chk(rd_data == q[0], "R3", "interleaved head", int'(rd_data), int'(q[0]));
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
            void'(q.pop_front());
            chk_flags();
        end
        drain("R3");

        finish_run();
    end
endmodule